// File: doc/BRIEF.md
# Hashed Translation Cache with Miss Replay

This block sits in a memory request path and turns descriptors that carry a virtual address into descriptors that carry a physical address. Each descriptor holds a requester number, a 48-bit virtual address, a length and a read/write flag. The page number is hashed to pick one slot of a direct-mapped table. A hit rewrites the address, attaches the destination server number stored in the entry and sends the descriptor on. A write that the entry does not permit leaves on a fault port.

A miss never triggers a local walk. The descriptor is copied out on a miss port for an external controller and is also held in a small replay buffer. The controller answers through a control port by installing the entry. Every held descriptor for that page is then reissued, oldest first, and now hits. The same control port can also remove an entry. All ports use valid/ready handshakes. Results leave through a single output stage, so they come out in the order they were looked up.

Top module: `vpx_xlate`

## Requirements
- R1: After reset no output valid is high, `req_ready` is high and every table slot is empty, so the first lookup of any page misses.
- R2: The page number is `va[47:12]` zero-extended to 40 bits. The slot index is the XOR of the page number cut into TBL_IDX_W-bit chunks, starting from bit 0, with the last chunk padded with zeros. A hit needs the entry's valid bit set and its 40-bit tag equal to the whole page number.
- R3: On a hit, the forward port carries `fwd_pa = {ppn, va[11:0]}` and `fwd_dst` = the entry's server number, and copies the requester, length and write flag unchanged. `fwd_valid` is high in the cycle after the request is accepted.
- R4: On a miss, the unchanged descriptor appears on the miss port and is held for replay.
- R5: A control command with `ctl_op`=0 writes tag, frame, permission and server into the hashed slot and overwrites any older entry there. Every held descriptor with the same page number is then reissued in arrival order and forwarded. Held descriptors of other pages stay held. Replays take priority over new requests.
- R6: When a request misses in the same cycle that a fill for its page is accepted, it is still replayed and forwarded without a further fill.
- R7: The permission field has valid at bit 0, read at bit 1, write at bit 2 and execute at bit 3. An entry with bit 0 clear behaves as a miss. A write request that hits an entry with bit 2 clear leaves on the fault port with its requester and address and is not forwarded.
- R8: A control command with `ctl_op`=1 clears the valid bit of the entry in the hashed slot only when that entry's tag equals the given page number. Otherwise it has no effect.
- R9: The replay buffer holds RB_DEPTH descriptors. While it is full and no replay is pending, `req_ready` is low.
- R10: At most one output valid is high at a time. An output whose ready is low keeps its valid and payload stable, and no new request is accepted meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_src | input | 8 | Requester number |
| req_va | input | 48 | Virtual address |
| req_len | input | 16 | Transfer length |
| req_wr | input | 1 | 1 = write, 0 = read |
| fwd_valid | output | 1 | Translated descriptor valid |
| fwd_ready | input | 1 | Downstream accepts translated descriptor |
| fwd_src | output | 8 | Requester number |
| fwd_pa | output | 52 | Physical address |
| fwd_dst | output | 8 | Destination server number |
| fwd_len | output | 16 | Transfer length |
| fwd_wr | output | 1 | Write flag |
| flt_valid | output | 1 | Permission fault valid |
| flt_ready | input | 1 | Fault accepted |
| flt_src | output | 8 | Requester of the faulting write |
| flt_va | output | 48 | Virtual address of the faulting write |
| mis_valid | output | 1 | Missed descriptor valid for the controller |
| mis_ready | input | 1 | Controller accepts missed descriptor |
| mis_src | output | 8 | Requester number |
| mis_va | output | 48 | Virtual address |
| mis_len | output | 16 | Transfer length |
| mis_wr | output | 1 | Write flag |
| ctl_valid | input | 1 | Control command valid |
| ctl_ready | output | 1 | Control command accepted |
| ctl_op | input | 1 | 0 = install entry, 1 = remove entry |
| ctl_vpn | input | 40 | Page number of the command |
| ctl_ppn | input | 40 | Frame number to install |
| ctl_perm | input | 4 | Permission bits to install |
| ctl_srv | input | 8 | Server number to install |

## Verification
The case where two functions meet in one cycle is a lookup that misses while the controller installs the entry for that same page. The lookup reads the table before the fill lands, so the descriptor must be held with its replay already armed. The bench drives a new request and the matching fill in the same cycle. The expected result is the descriptor on the miss port, then the same descriptor forwarded with the just-installed frame and server, with no second fill issued.

// File: rtl/vpx_pkg.sv
// Shared widths, entry and descriptor layouts for the translation cache.
// Assumes 4 KB pages and a 48-bit virtual address space.
package vpx_pkg;
    parameter int VA_W   = 48;
    parameter int OFF_W  = 12;
    parameter int VPN_W  = 40;
    parameter int PPN_W  = 40;
    parameter int SRV_W  = 8;
    parameter int SRC_W  = 8;
    parameter int LEN_W  = 16;
    parameter int PERM_W = 4;
    localparam int PA_W  = PPN_W + OFF_W;

    // Permission bit positions
    localparam int PB_VALID = 0;
    localparam int PB_READ  = 1;
    localparam int PB_WRITE = 2;
    localparam int PB_EXEC  = 3;

    // 96-bit table entry
    typedef struct packed {
        logic [VPN_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic [SRV_W-1:0]  srv;
        logic [3:0]        pad;
    } xent_t;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [VA_W-1:0]  va;
        logic [LEN_W-1:0] len;
        logic             wr;
    } desc_t;

    typedef enum logic [1:0] {K_FWD, K_FLT, K_MIS} okind_t;

    // Page number of a virtual address, zero-extended to the tag width
    function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
        return VPN_W'(va[VA_W-1:OFF_W]);
    endfunction
endpackage

// File: rtl/vpx_hash.sv
// XOR-folds a page number into a table index.
// Assumes nothing beyond IDX_W >= 1; the top chunk is zero-padded.
module vpx_hash
    import vpx_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    localparam int NCH = (VPN_W + IDX_W - 1) / IDX_W;

    logic [NCH*IDX_W-1:0] padded;
    assign padded = (NCH*IDX_W)'(vpn);

    // Fold all chunks together
    always_comb begin
        idx = '0;
        for (int c = 0; c < NCH; c++) begin
            idx = idx ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/vpx_table.sv
// Direct-mapped translation table: combinational lookup, registered
// install and remove from the control side. Assumes at most one control
// command per cycle (install wins if both are raised).
module vpx_table
    import vpx_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic             look_wok,
    output logic [PPN_W-1:0] look_ppn,
    output logic [SRV_W-1:0] look_srv,
    input  logic             do_fill,
    input  logic             do_inval,
    input  logic [VPN_W-1:0] ctl_vpn,
    input  xent_t            fill_ent
);
    xent_t            mem [DEPTH];
    xent_t            ent;
    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] ctl_idx;

    vpx_hash #(.IDX_W(IDX_W)) u_hash_look (.vpn(look_vpn), .idx(look_idx));
    vpx_hash #(.IDX_W(IDX_W)) u_hash_ctl  (.vpn(ctl_vpn),  .idx(ctl_idx));

    assign ent      = mem[look_idx];
    assign look_hit = ent.perm[PB_VALID] && (ent.tag == look_vpn);
    assign look_wok = ent.perm[PB_WRITE];
    assign look_ppn = ent.ppn;
    assign look_srv = ent.srv;

    // Table storage: clear on reset, install or conditionally remove
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_fill) begin
            mem[ctl_idx] <= fill_ent;
        end else if (do_inval && (mem[ctl_idx].tag == ctl_vpn)) begin
            mem[ctl_idx].perm[PB_VALID] <= 1'b0;
        end
    end
endmodule

// File: rtl/vpx_replay.sv
// Replay buffer for missed descriptors, kept as a compacting queue so
// slot 0 is the oldest. A fill arms every held descriptor of its page;
// the oldest armed one is offered for reissue. Assumes the caller never
// pushes into a full buffer unless it pops in the same cycle.
module vpx_replay
    import vpx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  desc_t            push_d,
    input  logic             push_arm,
    input  logic             fill,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             pop,
    output logic             has_arm,
    output desc_t            arm_d,
    output logic             full,
    output logic [CW-1:0]    cnt
);
    desc_t            slot   [DEPTH];
    desc_t            slot_n [DEPTH];
    logic [DEPTH-1:0] arm, arm_m, arm_n;
    logic [PW-1:0]    pidx;
    logic [CW-1:0]    cnt_p, cnt_n;

    // Oldest armed slot
    always_comb begin
        has_arm = 1'b0;
        pidx    = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (arm[i]) begin
                has_arm = 1'b1;
                pidx    = PW'(i);
            end
        end
    end

    assign arm_d = slot[pidx];
    assign full  = (cnt == CW'(DEPTH));

    // Next queue: arm by fill, remove popped slot, append pushed one
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            arm_m[i] = arm[i] | (fill && (CW'(i) < cnt) && (page_of(slot[i].va) == fill_vpn));
        end
        cnt_p = cnt - CW'(pop);
        cnt_n = cnt_p + CW'(push);
        for (int i = 0; i < DEPTH; i++) begin
            slot_n[i] = slot[i];
            arm_n[i]  = 1'b0;
            if (pop && (i >= int'(pidx))) begin
                if (i + 1 < DEPTH) begin
                    slot_n[i] = slot[i+1];
                    arm_n[i]  = arm_m[i+1];
                end
            end else begin
                arm_n[i] = arm_m[i];
            end
            if (push && (CW'(i) == cnt_p)) begin
                slot_n[i] = push_d;
                arm_n[i]  = push_arm;
            end
            if (CW'(i) >= cnt_n) arm_n[i] = 1'b0;
        end
    end

    // Queue state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            arm <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            cnt <= cnt_n;
            arm <= arm_n;
            for (int i = 0; i < DEPTH; i++) slot[i] <= slot_n[i];
        end
    end
endmodule

// File: rtl/vpx_xlate.sv
// Top of the translation cache. Picks a replay (first) or a new request,
// looks it up, and registers the result into one output stage that feeds
// the forward, fault or miss port. Misses are also held for replay.
// Assumes the controller sends at most one command per cycle.
module vpx_xlate
    import vpx_pkg::*;
#(
    parameter int TBL_IDX_W = 8,
    parameter int RB_DEPTH  = 8,
    localparam int CW = $clog2(RB_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SRC_W-1:0] req_src,
    input  logic [VA_W-1:0]  req_va,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_wr,
    output logic             fwd_valid,
    input  logic             fwd_ready,
    output logic [SRC_W-1:0] fwd_src,
    output logic [PA_W-1:0]  fwd_pa,
    output logic [SRV_W-1:0] fwd_dst,
    output logic [LEN_W-1:0] fwd_len,
    output logic             fwd_wr,
    output logic             flt_valid,
    input  logic             flt_ready,
    output logic [SRC_W-1:0] flt_src,
    output logic [VA_W-1:0]  flt_va,
    output logic             mis_valid,
    input  logic             mis_ready,
    output logic [SRC_W-1:0] mis_src,
    output logic [VA_W-1:0]  mis_va,
    output logic [LEN_W-1:0] mis_len,
    output logic             mis_wr,
    input  logic             ctl_valid,
    output logic             ctl_ready,
    input  logic             ctl_op,
    input  logic [VPN_W-1:0] ctl_vpn,
    input  logic [PPN_W-1:0] ctl_ppn,
    input  logic [PERM_W-1:0] ctl_perm,
    input  logic [SRV_W-1:0] ctl_srv
);
    logic             o_vld;
    okind_t           o_kind;
    desc_t            o_d;
    logic [PA_W-1:0]  o_pa;
    logic [SRV_W-1:0] o_dst;

    logic             stage_free, take_rp, take_new, take;
    logic             fill_acc, inval_acc;
    desc_t            new_d, cur, rp_d;
    logic [VPN_W-1:0] cur_vpn;
    logic             lk_hit, lk_wok;
    logic [PPN_W-1:0] lk_ppn;
    logic [SRV_W-1:0] lk_srv;
    okind_t           kind;
    logic             rp_has, rp_full;
    logic [CW-1:0]    rp_cnt;
    xent_t            fill_ent;

    assign ctl_ready = 1'b1;
    assign fill_acc  = ctl_valid && ctl_ready && !ctl_op;
    assign inval_acc = ctl_valid && ctl_ready && ctl_op;
    assign fill_ent  = '{tag: ctl_vpn, ppn: ctl_ppn, perm: ctl_perm, srv: ctl_srv, pad: '0};

    // Output stage can load when empty or being drained
    assign stage_free = !o_vld
                     || ((o_kind == K_FWD) && fwd_ready)
                     || ((o_kind == K_FLT) && flt_ready)
                     || ((o_kind == K_MIS) && mis_ready);

    assign take_rp   = rp_has && stage_free;
    assign req_ready = stage_free && !rp_has && !rp_full;
    assign take_new  = req_valid && req_ready;
    assign take      = take_rp || take_new;

    assign new_d   = '{src: req_src, va: req_va, len: req_len, wr: req_wr};
    assign cur     = rp_has ? rp_d : new_d;
    assign cur_vpn = page_of(cur.va);

    vpx_table #(.IDX_W(TBL_IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_vpn (cur_vpn),
        .look_hit (lk_hit),
        .look_wok (lk_wok),
        .look_ppn (lk_ppn),
        .look_srv (lk_srv),
        .do_fill  (fill_acc),
        .do_inval (inval_acc),
        .ctl_vpn  (ctl_vpn),
        .fill_ent (fill_ent)
    );

    vpx_replay #(.DEPTH(RB_DEPTH)) u_replay (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take && !lk_hit),
        .push_d   (cur),
        .push_arm (fill_acc && (ctl_vpn == cur_vpn)),
        .fill     (fill_acc),
        .fill_vpn (ctl_vpn),
        .pop      (take_rp),
        .has_arm  (rp_has),
        .arm_d    (rp_d),
        .full     (rp_full),
        .cnt      (rp_cnt)
    );

    // Classify the lookup result
    always_comb begin
        if (!lk_hit)               kind = K_MIS;
        else if (cur.wr && !lk_wok) kind = K_FLT;
        else                       kind = K_FWD;
    end

    // Single output register keeps results in lookup order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_kind <= K_FWD;
            o_d    <= '0;
            o_pa   <= '0;
            o_dst  <= '0;
        end else if (stage_free) begin
            o_vld <= take;
            if (take) begin
                o_kind <= kind;
                o_d    <= cur;
                o_pa   <= {lk_ppn, cur.va[OFF_W-1:0]};
                o_dst  <= lk_srv;
            end
        end
    end

    assign fwd_valid = o_vld && (o_kind == K_FWD);
    assign fwd_src   = o_d.src;
    assign fwd_pa    = o_pa;
    assign fwd_dst   = o_dst;
    assign fwd_len   = o_d.len;
    assign fwd_wr    = o_d.wr;
    assign flt_valid = o_vld && (o_kind == K_FLT);
    assign flt_src   = o_d.src;
    assign flt_va    = o_d.va;
    assign mis_valid = o_vld && (o_kind == K_MIS);
    assign mis_src   = o_d.src;
    assign mis_va    = o_d.va;
    assign mis_len   = o_d.len;
    assign mis_wr    = o_d.wr;
endmodule

// File: rtl/vpx_chk.sv
// Property checker for the translation cache, attached by bind.
module vpx_chk
    import vpx_pkg::*;
#(
    parameter int RB_DEPTH = 8,
    localparam int CW = $clog2(RB_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             fwd_valid,
    input logic             fwd_ready,
    input logic [SRC_W-1:0] fwd_src,
    input logic [PA_W-1:0]  fwd_pa,
    input logic [SRV_W-1:0] fwd_dst,
    input logic             flt_valid,
    input logic             mis_valid,
    input logic [CW-1:0]    rp_cnt
);
    // R10
    one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, flt_valid, mis_valid}));

    // R10
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_pa) && $stable(fwd_dst) && $stable(fwd_src)));

    // R3
    result_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (fwd_valid || flt_valid || mis_valid));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_cnt <= CW'(RB_DEPTH));
endmodule

bind vpx_xlate vpx_chk #(.RB_DEPTH(RB_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_src   (fwd_src),
    .fwd_pa    (fwd_pa),
    .fwd_dst   (fwd_dst),
    .flt_valid (flt_valid),
    .mis_valid (mis_valid),
    .rp_cnt    (rp_cnt)
);

// File: tb/vpx_xlate_test.sv
`timescale 1ns/1ps
// Bench for the translation cache: 16-slot table, 4-deep replay buffer.
module vpx_xlate_test;
    import vpx_pkg::*;

    localparam int IW = 4;
    localparam int RD = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic req_valid, req_ready, req_wr;
    logic [7:0] req_src;
    logic [47:0] req_va;
    logic [15:0] req_len;
    logic fwd_valid, fwd_ready, fwd_wr;
    logic [7:0] fwd_src, fwd_dst;
    logic [51:0] fwd_pa;
    logic [15:0] fwd_len;
    logic flt_valid, flt_ready;
    logic [7:0] flt_src;
    logic [47:0] flt_va;
    logic mis_valid, mis_ready, mis_wr;
    logic [7:0] mis_src;
    logic [47:0] mis_va;
    logic [15:0] mis_len;
    logic ctl_valid, ctl_ready, ctl_op;
    logic [39:0] ctl_vpn, ctl_ppn;
    logic [3:0] ctl_perm;
    logic [7:0] ctl_srv;

    vpx_xlate #(.TBL_IDX_W(IW), .RB_DEPTH(RD)) uut (.*);

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Output log: kind 0 forward, 1 fault, 2 miss
    int          lg_kind [256];
    logic [7:0]  lg_src  [256];
    logic [51:0] lg_a    [256];
    logic [7:0]  lg_dst  [256];
    logic [15:0] lg_len  [256];
    logic        lg_wr   [256];
    int wp = 0;
    int rp = 0;

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (fwd_valid && fwd_ready) begin
                lg_kind[wp] = 0; lg_src[wp] = fwd_src; lg_a[wp] = fwd_pa;
                lg_dst[wp] = fwd_dst; lg_len[wp] = fwd_len; lg_wr[wp] = fwd_wr; wp++;
            end
            if (flt_valid && flt_ready) begin
                lg_kind[wp] = 1; lg_src[wp] = flt_src; lg_a[wp] = 52'(flt_va);
                lg_dst[wp] = 8'h0; lg_len[wp] = 16'h0; lg_wr[wp] = 1'b0; wp++;
            end
            if (mis_valid && mis_ready) begin
                lg_kind[wp] = 2; lg_src[wp] = mis_src; lg_a[wp] = 52'(mis_va);
                lg_dst[wp] = 8'h0; lg_len[wp] = mis_len; lg_wr[wp] = mis_wr; wp++;
            end
        end
    end

    function automatic logic [47:0] mkva(input logic [39:0] vpn, input logic [11:0] off);
        return {vpn[35:0], off};
    endfunction

    task automatic chk(input string req, input int kind, input logic [7:0] src,
                       input logic [51:0] a, input logic [7:0] dst,
                       input logic [15:0] len, input logic wr);
        checks++;
        if (rp >= wp) begin
            errors++;
            $display("FAIL %s: no output recorded, expected kind=%0d src=%h a=%h", req, kind, src, a);
        end else begin
            if (lg_kind[rp] != kind || lg_src[rp] != src || lg_a[rp] != a ||
                lg_dst[rp] != dst || lg_len[rp] != len || lg_wr[rp] != wr) begin
                errors++;
                $display("FAIL %s: got kind=%0d src=%h a=%h dst=%h len=%h wr=%b, expected kind=%0d src=%h a=%h dst=%h len=%h wr=%b",
                         req, lg_kind[rp], lg_src[rp], lg_a[rp], lg_dst[rp], lg_len[rp], lg_wr[rp],
                         kind, src, a, dst, len, wr);
            end
            rp++;
        end
    endtask

    task automatic chkv(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] s, input logic [47:0] va,
                        input logic [15:0] ln, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_src = s; req_va = va; req_len = ln; req_wr = w;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic ctl(input logic op, input logic [39:0] vpn, input logic [39:0] ppn,
                       input logic [3:0] perm, input logic [7:0] srv);
        @(negedge clk);
        ctl_valid = 1'b1; ctl_op = op; ctl_vpn = vpn; ctl_ppn = ppn; ctl_perm = perm; ctl_srv = srv;
        @(posedge clk);
        #1 ctl_valid = 1'b0;
    endtask

    // Test pages and their expected slots (XOR fold of nibbles)
    localparam logic [39:0] BASE = 40'h0A_BCDE_F000;
    localparam logic [39:0] PZ = 40'h999_9999;
    localparam logic [39:0] PP = 40'h111_1111;
    localparam logic [39:0] PQ = 40'h222_2223;
    localparam logic [39:0] PR = 40'h333_3330;
    localparam logic [39:0] PS = 40'h444_4444;
    localparam logic [39:0] PT = 40'h555_5555;
    localparam logic [39:0] PW = 40'h666_6666;
    localparam logic [39:0] PU = 40'h777_7777;

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_src = '0; req_va = '0; req_len = '0; req_wr = 1'b0;
        fwd_ready = 1'b1; flt_ready = 1'b1; mis_ready = 1'b1;
        ctl_valid = 1'b0; ctl_op = 1'b0; ctl_vpn = '0; ctl_ppn = '0; ctl_perm = '0; ctl_srv = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: idle outputs and ready after reset
        chkv("R1 valids", {61'b0, fwd_valid, flt_valid, mis_valid}, 64'd0);
        chkv("R1 ready", 64'(req_ready), 64'd1);

        // R1/R4: empty table misses; descriptor unchanged on miss port
        send(8'h01, mkva(PZ, 12'h123), 16'd32, 1'b0);
        idle(3);
        chk("R1 R4 miss after reset", 2, 8'h01, 52'(mkva(PZ, 12'h123)), 8'h0, 16'd32, 1'b0);
        ctl(1'b0, PZ, 40'h12_3456_789A, 4'b0011, 8'h09);
        idle(3);
        chk("R5 replay after fill", 0, 8'h01, {40'h12_3456_789A, 12'h123}, 8'h09, 16'd32, 1'b0);

        // R2/R3: fill 16 pages landing in 16 distinct slots, then hit each
        for (int k = 0; k < 16; k++)
            ctl(1'b0, BASE + 40'(k), 40'h100 + 40'(k) * 40'h101, 4'b0111, 8'h20 + 8'(k));
        for (int k = 0; k < 16; k++)
            send(8'(k), mkva(BASE + 40'(k), 12'(k * 273)), 16'(64 + k), (k % 2) == 1);
        idle(4);
        for (int k = 0; k < 16; k++)
            chk("R2 R3 sweep hit", 0, 8'(k), {40'h100 + 40'(k) * 40'h101, 12'(k * 273)},
                8'h20 + 8'(k), 16'(64 + k), (k % 2) == 1);

        // R3: result valid in the cycle after acceptance
        send(8'h30, mkva(BASE + 40'd5, 12'hFFF), 16'd8, 1'b0);
        @(negedge clk);
        chkv("R3 latency", 64'(fwd_valid), 64'd1);
        idle(2);
        chk("R3 offset pass", 0, 8'h30, {40'h100 + 40'd5 * 40'h101, 12'hFFF}, 8'h25, 16'd8, 1'b0);

        // R2/R5: alias with the same slot but a different tag overwrites
        ctl(1'b0, BASE ^ 40'h11, 40'hAA_0000, 4'b0011, 8'h55);
        send(8'h40, mkva(BASE, 12'h010), 16'd4, 1'b0);
        send(8'h41, mkva(BASE ^ 40'h11, 12'h020), 16'd4, 1'b0);
        idle(3);
        chk("R2 tag mismatch misses", 2, 8'h40, 52'(mkva(BASE, 12'h010)), 8'h0, 16'd4, 1'b0);
        chk("R5 overwrite hit", 0, 8'h41, {40'hAA_0000, 12'h020}, 8'h55, 16'd4, 1'b0);
        ctl(1'b0, BASE, 40'h100, 4'b0111, 8'h20);
        idle(3);
        chk("R5 refill replay", 0, 8'h40, {40'h100, 12'h010}, 8'h20, 16'd4, 1'b0);

        // R5: replays per page, in arrival order, others stay held
        send(8'h01, mkva(PP, 12'h001), 16'd1, 1'b0);
        send(8'h02, mkva(PQ, 12'h002), 16'd2, 1'b1);
        send(8'h03, mkva(PP, 12'h003), 16'd3, 1'b1);
        idle(3);
        chk("R4 miss 1", 2, 8'h01, 52'(mkva(PP, 12'h001)), 8'h0, 16'd1, 1'b0);
        chk("R4 miss 2", 2, 8'h02, 52'(mkva(PQ, 12'h002)), 8'h0, 16'd2, 1'b1);
        chk("R4 miss 3", 2, 8'h03, 52'(mkva(PP, 12'h003)), 8'h0, 16'd3, 1'b1);
        ctl(1'b0, PP, 40'hB_0000, 4'b0111, 8'h71);
        idle(5);
        chk("R5 order first", 0, 8'h01, {40'hB_0000, 12'h001}, 8'h71, 16'd1, 1'b0);
        chk("R5 order second", 0, 8'h03, {40'hB_0000, 12'h003}, 8'h71, 16'd3, 1'b1);
        chkv("R5 other page held", 64'(wp - rp), 64'd0);
        ctl(1'b0, PQ, 40'hC_0000, 4'b0111, 8'h72);
        idle(3);
        chk("R5 second page", 0, 8'h02, {40'hC_0000, 12'h002}, 8'h72, 16'd2, 1'b1);

        // R9: buffer full stalls new requests
        for (int k = 0; k < RD; k++) send(8'h10 + 8'(k), mkva(PR, 12'(k)), 16'd16, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_src = 8'h1F; req_va = mkva(PS, 12'h0); req_len = 16'd1; req_wr = 1'b0;
        @(negedge clk);
        chkv("R9 full blocks", 64'(req_ready), 64'd0);
        idle(3);
        chkv("R9 still blocked", 64'(req_ready), 64'd0);
        req_valid = 1'b0;
        for (int k = 0; k < RD; k++)
            chk("R9 held miss", 2, 8'h10 + 8'(k), 52'(mkva(PR, 12'(k))), 8'h0, 16'd16, 1'b0);
        ctl(1'b0, PR, 40'hD_0000, 4'b0011, 8'h73);
        idle(8);
        for (int k = 0; k < RD; k++)
            chk("R9 drain order", 0, 8'h10 + 8'(k), {40'hD_0000, 12'(k)}, 8'h73, 16'd16, 1'b0);
        chkv("R9 ready again", 64'(req_ready), 64'd1);

        // R7: write without permission faults; read forwards
        ctl(1'b0, PS, 40'hE_0000, 4'b0011, 8'h66);
        send(8'h50, mkva(PS, 12'h444), 16'd4, 1'b1);
        send(8'h51, mkva(PS, 12'h445), 16'd4, 1'b0);
        idle(3);
        chk("R7 write fault", 1, 8'h50, 52'(mkva(PS, 12'h444)), 8'h0, 16'd0, 1'b0);
        chk("R7 read allowed", 0, 8'h51, {40'hE_0000, 12'h445}, 8'h66, 16'd4, 1'b0);
        ctl(1'b0, PT, 40'hF_0000, 4'b0110, 8'h67);
        send(8'h52, mkva(PT, 12'h555), 16'd4, 1'b0);
        idle(3);
        chk("R7 valid clear misses", 2, 8'h52, 52'(mkva(PT, 12'h555)), 8'h0, 16'd4, 1'b0);
        ctl(1'b0, PT, 40'hF_0001, 4'b0011, 8'h68);
        idle(3);
        chk("R7 valid set replays", 0, 8'h52, {40'hF_0001, 12'h555}, 8'h68, 16'd4, 1'b0);

        // R8: remove with other tag has no effect; with own tag it clears
        ctl(1'b1, PS ^ 40'h11, 40'h0, 4'b0, 8'h0);
        send(8'h53, mkva(PS, 12'h001), 16'd4, 1'b0);
        idle(3);
        chk("R8 mismatch ignored", 0, 8'h53, {40'hE_0000, 12'h001}, 8'h66, 16'd4, 1'b0);
        ctl(1'b1, PS, 40'h0, 4'b0, 8'h0);
        send(8'h54, mkva(PS, 12'h002), 16'd4, 1'b0);
        idle(3);
        chk("R8 removed misses", 2, 8'h54, 52'(mkva(PS, 12'h002)), 8'h0, 16'd4, 1'b0);
        ctl(1'b0, PS, 40'hE_0000, 4'b0011, 8'h66);
        idle(3);
        chk("R8 reinstall replays", 0, 8'h54, {40'hE_0000, 12'h002}, 8'h66, 16'd4, 1'b0);

        // R6: miss and fill of the same page in one cycle
        @(negedge clk);
        chkv("R6 ready", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_src = 8'h60; req_va = mkva(PW, 12'h666); req_len = 16'd6; req_wr = 1'b0;
        ctl_valid = 1'b1; ctl_op = 1'b0; ctl_vpn = PW; ctl_ppn = 40'h6_6000; ctl_perm = 4'b0011; ctl_srv = 8'h76;
        @(posedge clk);
        #1 req_valid = 1'b0; ctl_valid = 1'b0;
        idle(4);
        chk("R6 miss reported", 2, 8'h60, 52'(mkva(PW, 12'h666)), 8'h0, 16'd6, 1'b0);
        chk("R6 replayed", 0, 8'h60, {40'h6_6000, 12'h666}, 8'h76, 16'd6, 1'b0);

        // R10: stalled forward output holds and blocks new requests
        ctl(1'b0, PU, 40'h7_7000, 4'b0011, 8'h77);
        fwd_ready = 1'b0;
        send(8'h70, mkva(PU, 12'h777), 16'd7, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chkv("R10 hold", {11'b0, fwd_valid, fwd_pa}, {11'b0, 1'b1, 40'h7_7000, 12'h777});
            chkv("R10 blocked", 64'(req_ready), 64'd0);
        end
        fwd_ready = 1'b1;
        idle(2);
        chk("R10 released", 0, 8'h70, {40'h7_7000, 12'h777}, 8'h77, 16'd7, 1'b0);
        chkv("R10 single output", 64'(wp - rp), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule